// File: doc/BRIEF.md
# Palette-Indexed Double-Buffered TFT Panel Controller

This block drives a small TFT panel over a parallel 24-line RGB bus. Every pixel is kept as a 3-bit colour index, and each index expands to an 18-bit colour through an eight-entry palette that the host can program. Two on-chip frame stores hold these indices. The scan-out path reads the displayed store, called the front buffer. A one-pixel-per-cycle draw port writes the other store, called the back buffer. Because only small indices are stored, a full frame needs far less memory than it would at full colour.

To show a finished drawing, the host pulses a swap request. A small state machine latches the request and exchanges the two buffer roles only at the start of the first vertical blanking line. The picture therefore never shows a frame that is partly redrawn. When the roles have exchanged, the block raises a one-cycle done pulse. The panel receives the system clock as its pixel clock, together with data-enable, horizontal sync and vertical sync. These controls are delayed by one cycle so that they line up with the registered palette lookup.

The default geometry is a 32x8 active area with short porches, which keeps the default stores small. The same parameters describe a 480x272 panel at about 9 MHz and 60 Hz, with horizontal 2/41/2 and vertical 2/10/2 for front porch/sync/back porch.

Top module: `lcdp_ctrl`

## Requirements
- R1: While reset is asserted, the outputs are as follows: `lcd_de` is low, `lcd_rgb` is zero, `lcd_hs` and `lcd_vs` are at their inactive level (high by default), `swap_done` is low, and buffer 0 is the front buffer.
- R2: For each active pixel, the output shows the palette entry selected by the 3-bit index stored at that position in the front buffer. A palette entry holds red in bits 17:12, green in bits 11:6 and blue in bits 5:0. On the RGB bus, red occupies bits 23:16, green bits 15:8 and blue bits 7:0. Each 8-bit channel is the 6-bit value followed by a copy of its two top bits.
- R3: A palette write accepted at a clock edge is used by every lookup at a later edge. Colour writes may happen at any time, including during active scan.
- R4: Each line consists of H_ACT active pixels, then the front porch, then the sync, then the back porch. Lines are ordered the same way vertically. `lcd_de` is high exactly for active pixels, and `lcd_rgb` is zero whenever `lcd_de` is low.
- R5: The syncs are active-low by default, with the polarity set by parameter. `lcd_vs` covers whole lines. The syncs, `lcd_de` and `lcd_rgb` describe the position the counters held one cycle earlier, so all of them share the same one-cycle latency.
- R6: Swap state machine. IDLE goes to WAIT on a request. WAIT goes to DONE at the edge that starts line V_ACT, column 0; the buffer roles exchange at that same edge. DONE lasts one cycle, with `swap_done` high, and then goes to WAIT if a request is present or to IDLE otherwise. A request made while in WAIT adds nothing.
- R7: Every draw write goes to the current back buffer. A write accepted at the same edge as the role exchange lands in the buffer that was the back buffer before that edge.
- R8: A draw with x ≥ H_ACT or y ≥ V_ACT changes no stored pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used as the pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| draw_en | input | 1 | Draw write strobe |
| draw_x | input | COORD_W | Draw column |
| draw_y | input | COORD_W | Draw row |
| draw_idx | input | 3 | Colour index to store |
| pal_we | input | 1 | Palette write strobe |
| pal_sel | input | 3 | Palette entry to write |
| pal_color | input | 18 | 6:6:6 colour value |
| swap_req | input | 1 | Request a buffer exchange |
| swap_done | output | 1 | One-cycle pulse after the exchange |
| lcd_pclk | output | 1 | Pixel clock to the panel |
| lcd_de | output | 1 | Data enable |
| lcd_hs | output | 1 | Horizontal sync |
| lcd_vs | output | 1 | Vertical sync |
| lcd_rgb | output | 24 | Pixel colour, red in the top byte |

## Verification
All panel outputs appear one edge after the counter position they describe. Palette and draw writes take effect for lookups from the edge after their own edge onward. The role exchange happens at the edge that starts line V_ACT, and `swap_done` is high in the cycle after that edge. The bench model updates at every rising edge in exactly this order: first it takes the lookup from the old state, then it applies the writes, then it steps the swap state machine and the counters. The outputs are compared at the following falling edge. Colour comparisons start only after both stores have been filled completely.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;
    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_WAIT = 2'd1,
        SW_DONE = 2'd2
    } swap_st_t;

    localparam int IDX_W  = 3;
    localparam int PAL_N  = 1 << IDX_W;
    localparam int COL_W  = 18;
    localparam int CH_W   = COL_W / 3;
    localparam int RGB_W  = 24;
endpackage

// File: rtl/lcdp_timing.sv
module lcdp_timing #(
    parameter int H_ACT = 32,
    parameter int H_FP  = 2,
    parameter int H_SW  = 4,
    parameter int H_BP  = 2,
    parameter int V_ACT = 8,
    parameter int V_FP  = 1,
    parameter int V_SW  = 2,
    parameter int V_BP  = 1,
    parameter int HW    = $clog2(H_ACT + H_FP + H_SW + H_BP),
    parameter int VW    = $clog2(V_ACT + V_FP + V_SW + V_BP)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          pix_act,
    output logic          hs_on,
    output logic          vs_on,
    output logic          blank_start
);
    localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
    localparam logic [HW-1:0] H_END  = HW'(H_TOT - 1);
    localparam logic [VW-1:0] V_END  = VW'(V_TOT - 1);
    localparam logic [HW-1:0] H_AC   = HW'(H_ACT);
    localparam logic [VW-1:0] V_AC   = VW'(V_ACT);
    localparam logic [HW-1:0] HS_BEG = HW'(H_ACT + H_FP);
    localparam logic [HW-1:0] HS_END = HW'(H_ACT + H_FP + H_SW);
    localparam logic [VW-1:0] VS_BEG = VW'(V_ACT + V_FP);
    localparam logic [VW-1:0] VS_END = VW'(V_ACT + V_FP + V_SW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (hcnt == H_END) begin
            hcnt <= '0;
            vcnt <= (vcnt == V_END) ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    assign pix_act     = (hcnt < H_AC) && (vcnt < V_AC);
    assign hs_on       = (hcnt >= HS_BEG) && (hcnt < HS_END);
    assign vs_on       = (vcnt >= VS_BEG) && (vcnt < VS_END);
    assign blank_start = (hcnt == '0) && (vcnt == V_AC);
endmodule

// File: rtl/lcdp_fbuf.sv
module lcdp_fbuf #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [IW-1:0] wr_idx,
    input  logic          front_sel,
    input  logic [AW-1:0] rd_addr,
    output logic [IW-1:0] rd_idx
);
    logic [IW-1:0] bank_q [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [IW-1:0] mem [DEPTH];
        // the back bank is the one not being displayed
        always_ff @(posedge clk) begin
            if (wr_en && (front_sel != 1'(b)))
                mem[wr_addr] <= wr_idx;
        end
        assign bank_q[b] = mem[rd_addr];
    end

    assign rd_idx = front_sel ? bank_q[1] : bank_q[0];
endmodule

// File: rtl/lcdp_pal.sv
module lcdp_pal
    import lcdp_pkg::*;
#(
    parameter bit FILL_REPL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wsel,
    input  logic [COL_W-1:0] wdata,
    input  logic [IDX_W-1:0] idx,
    input  logic             act,
    output logic [RGB_W-1:0] rgb
);
    logic [COL_W-1:0] entry [PAL_N];
    logic [COL_W-1:0] pick;
    logic [RGB_W-1:0] wide;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAL_N; i++) entry[i] <= '0;
        end else if (we) begin
            entry[wsel] <= wdata;
        end
    end

    assign pick = entry[idx];

    for (genvar c = 0; c < 3; c++) begin : g_chan
        localparam int SRC = c * CH_W;
        localparam int DST = c * 8;
        if (FILL_REPL) begin : g_rep
            assign wide[DST +: 8] = {pick[SRC +: CH_W], pick[SRC + CH_W - 1 -: 2]};
        end else begin : g_zero
            assign wide[DST +: 8] = {pick[SRC +: CH_W], 2'b00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rgb <= '0;
        else        rgb <= act ? wide : '0;
    end
endmodule

// File: rtl/lcdp_ctrl.sv
module lcdp_ctrl
    import lcdp_pkg::*;
#(
    parameter int H_ACT          = 32,
    parameter int H_FP           = 2,
    parameter int H_SW           = 4,
    parameter int H_BP           = 2,
    parameter int V_ACT          = 8,
    parameter int V_FP           = 1,
    parameter int V_SW           = 2,
    parameter int V_BP           = 1,
    parameter int COORD_W        = 10,
    parameter bit HS_ACTIVE_HIGH = 1'b0,
    parameter bit VS_ACTIVE_HIGH = 1'b0,
    parameter bit FILL_REPL      = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               draw_en,
    input  logic [COORD_W-1:0] draw_x,
    input  logic [COORD_W-1:0] draw_y,
    input  logic [IDX_W-1:0]   draw_idx,
    input  logic               pal_we,
    input  logic [IDX_W-1:0]   pal_sel,
    input  logic [COL_W-1:0]   pal_color,
    input  logic               swap_req,
    output logic               swap_done,
    output logic               lcd_pclk,
    output logic               lcd_de,
    output logic               lcd_hs,
    output logic               lcd_vs,
    output logic [RGB_W-1:0]   lcd_rgb
);
    localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
    localparam int HW    = $clog2(H_TOT);
    localparam int VW    = $clog2(V_TOT);
    localparam int DEPTH = H_ACT * V_ACT;
    localparam int AW    = $clog2(DEPTH);

    logic [HW-1:0]    hcnt;
    logic [VW-1:0]    vcnt;
    logic             pix_act, hs_on, vs_on, blank_start;
    logic             front_sel;
    logic             flip;
    swap_st_t         st_q, st_d;
    logic [AW-1:0]    rd_addr, wr_addr;
    logic [IDX_W-1:0] rd_idx;
    logic             in_area;

    lcdp_timing #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) u_tim (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
        .pix_act(pix_act), .hs_on(hs_on), .vs_on(vs_on),
        .blank_start(blank_start)
    );

    // swap state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SW_IDLE;
        else        st_q <= st_d;
    end

    // swap state machine: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SW_IDLE: if (swap_req)    st_d = SW_WAIT;
            SW_WAIT: if (blank_start) st_d = SW_DONE;
            SW_DONE: st_d = swap_req ? SW_WAIT : SW_IDLE;
            default: st_d = SW_IDLE;
        endcase
    end

    // swap state machine: outputs
    always_comb begin
        flip      = (st_q == SW_WAIT) && blank_start;
        swap_done = (st_q == SW_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    front_sel <= 1'b0;
        else if (flip) front_sel <= ~front_sel;
    end

    assign in_area = (32'(draw_x) < H_ACT) && (32'(draw_y) < V_ACT);
    assign wr_addr = in_area ? AW'(32'(draw_y) * H_ACT + 32'(draw_x)) : '0;
    assign rd_addr = pix_act ? AW'(32'(vcnt) * H_ACT + 32'(hcnt)) : '0;

    lcdp_fbuf #(.DEPTH(DEPTH), .AW(AW), .IW(IDX_W)) u_fb (
        .clk(clk), .wr_en(draw_en && in_area), .wr_addr(wr_addr),
        .wr_idx(draw_idx), .front_sel(front_sel),
        .rd_addr(rd_addr), .rd_idx(rd_idx)
    );

    lcdp_pal #(.FILL_REPL(FILL_REPL)) u_pal (
        .clk(clk), .rst_n(rst_n), .we(pal_we), .wsel(pal_sel),
        .wdata(pal_color), .idx(rd_idx), .act(pix_act), .rgb(lcd_rgb)
    );

    // controls delayed one cycle to match the palette register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcd_de <= 1'b0;
            lcd_hs <= ~HS_ACTIVE_HIGH;
            lcd_vs <= ~VS_ACTIVE_HIGH;
        end else begin
            lcd_de <= pix_act;
            lcd_hs <= HS_ACTIVE_HIGH ? hs_on : ~hs_on;
            lcd_vs <= VS_ACTIVE_HIGH ? vs_on : ~vs_on;
        end
    end

    assign lcd_pclk = clk;
endmodule

// File: rtl/lcdp_chk.sv
module lcdp_chk #(
    parameter int HW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          swap_done,
    input logic          front_sel,
    input logic [HW-1:0] hcnt,
    input logic          lcd_de,
    input logic          lcd_vs,
    input logic [23:0]   lcd_rgb
);
    a_r4_dark_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_de |-> (lcd_rgb == 24'd0));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        swap_done |=> !swap_done);

    a_r6_done_follows_flip: assert property (@(posedge clk) disable iff (!rst_n)
        swap_done |-> (front_sel != $past(front_sel)));

    a_r6_flip_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (front_sel != $past(front_sel)) |-> swap_done);

    a_r5_vs_whole_line: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt != HW'(1)) |-> $stable(lcd_vs));
endmodule

bind lcdp_ctrl lcdp_chk #(.HW(HW)) u_chk (
    .clk(clk), .rst_n(rst_n), .swap_done(swap_done), .front_sel(front_sel),
    .hcnt(hcnt), .lcd_de(lcd_de), .lcd_vs(lcd_vs), .lcd_rgb(lcd_rgb)
);

// File: tb/sim_lcdp_ctrl.sv
module sim_lcdp_ctrl;
    localparam int HA = 32, HF = 2, HS = 4, HB = 2;
    localparam int VA = 8,  VF = 1, VS = 2, VB = 1;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        draw_en = 1'b0;
    logic [9:0]  draw_x = '0, draw_y = '0;
    logic [2:0]  draw_idx = '0;
    logic        pal_we = 1'b0;
    logic [2:0]  pal_sel = '0;
    logic [17:0] pal_color = '0;
    logic        swap_req = 1'b0;
    logic        swap_done, lcd_pclk, lcd_de, lcd_hs, lcd_vs;
    logic [23:0] lcd_rgb;

    int n_tests = 0, n_fail = 0, cyc = 0;

    lcdp_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .draw_en(draw_en), .draw_x(draw_x),
        .draw_y(draw_y), .draw_idx(draw_idx), .pal_we(pal_we),
        .pal_sel(pal_sel), .pal_color(pal_color), .swap_req(swap_req),
        .swap_done(swap_done), .lcd_pclk(lcd_pclk), .lcd_de(lcd_de),
        .lcd_hs(lcd_hs), .lcd_vs(lcd_vs), .lcd_rgb(lcd_rgb)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    int          m_hc, m_vc, m_front, m_sw;
    logic [2:0]  m_fb [2][HA*VA];
    logic [17:0] m_pal [8];
    logic        e_de, e_hs, e_vs, e_done;
    logic [23:0] e_rgb;
    bit          rgb_ok = 0;
    int          done_seen = 0;

    function automatic logic [23:0] expand(logic [17:0] c);
        logic [5:0] r, g, b;
        r = c[17:12]; g = c[11:6]; b = c[5:0];
        return {r, r[5:4], g, g[5:4], b, b[5:4]};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hc = 0; m_vc = 0; m_front = 0; m_sw = 0;
            for (int i = 0; i < 8; i++) m_pal[i] = '0;
            e_de = 0; e_hs = 1; e_vs = 1; e_done = 0; e_rgb = '0;
        end else begin
            bit act, blank;
            act   = (m_hc < HA) && (m_vc < VA);
            e_de  = act;
            e_hs  = !(m_hc >= HA + HF && m_hc < HA + HF + HS);
            e_vs  = !(m_vc >= VA + VF && m_vc < VA + VF + VS);
            e_rgb = act ? expand(m_pal[m_fb[m_front][m_vc * HA + m_hc]]) : '0;
            if (pal_we) m_pal[pal_sel] = pal_color;
            if (draw_en && draw_x < HA && draw_y < VA)
                m_fb[1 - m_front][draw_y * HA + draw_x] = draw_idx;
            blank = (m_hc == 0) && (m_vc == VA);
            case (m_sw)
                0: if (swap_req) m_sw = 1;
                1: if (blank) begin m_front = 1 - m_front; m_sw = 2; end
                default: m_sw = swap_req ? 1 : 0;
            endcase
            e_done = (m_sw == 2);
            if (m_hc == HT - 1) begin
                m_hc = 0;
                m_vc = (m_vc == VT - 1) ? 0 : m_vc + 1;
            end else begin
                m_hc = m_hc + 1;
            end
        end
    end

    task automatic check(bit ok, string req, logic [23:0] act, logic [23:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            check(lcd_de == 0 && lcd_rgb == 0 && lcd_hs && lcd_vs && !swap_done,
                  "R1 reset state", {lcd_de, lcd_hs, lcd_vs, swap_done}, 4'b0110);
        end else begin
            check(lcd_de === e_de, "R4 data enable", lcd_de, e_de);
            check(lcd_hs === e_hs, "R5 hsync", lcd_hs, e_hs);
            check(lcd_vs === e_vs, "R5 vsync", lcd_vs, e_vs);
            check(swap_done === e_done, "R6 swap done", swap_done, e_done);
            if (!e_de)
                check(lcd_rgb === 24'd0, "R4 rgb zero in blanking", lcd_rgb, 24'd0);
            else if (rgb_ok)
                check(lcd_rgb === e_rgb, "R2 R3 R7 R8 pixel colour", lcd_rgb, e_rgb);
            if (swap_done) done_seen++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic draw(int x, int y, int idx);
        draw_en = 1; draw_x = 10'(x); draw_y = 10'(y); draw_idx = 3'(idx);
        @(negedge clk);
        draw_en = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!swap_done && n < 3 * HT * VT) begin @(negedge clk); n++; end
        check(swap_done === 1'b1, "R6 swap completes", swap_done, 1);
        @(negedge clk);
    endtask

    task automatic pulse_swap();
        swap_req = 1; @(negedge clk); swap_req = 0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R3: program palette
        for (int i = 0; i < 8; i++) begin
            pal_we = 1; pal_sel = 3'(i);
            pal_color = {6'(i * 9), 6'(63 - i * 7), 6'(i * 5 + 3)};
            @(negedge clk);
        end
        pal_we = 0;
        // R7, R8: fill back store with out-of-range draws mixed in
        for (int y = 0; y < VA; y++)
            for (int x = 0; x < HA; x++) draw(x, y, (x + y) % 8);
        draw(HA, 0, 7); draw(0, VA, 7); draw(HA + 5, VA + 1, 7); draw(1023, 2, 7);
        pulse_swap();
        wait_done();
        for (int y = 0; y < VA; y++)
            for (int x = 0; x < HA; x++) draw(x, y, (x ^ y) % 8);
        pulse_swap();
        wait_done();
        rgb_ok = 1;
        // R8: out-of-range writes aimed at aliases of visible pixels
        draw(HA, 0, 5); draw(HA + 1, 3, 5); draw(0, VA, 5);
        pulse_swap();
        wait_done();
        repeat (HT * VT) @(negedge clk);
        // R3: palette updates during active scan
        while (!(m_vc == 2 && m_hc == 5)) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            pal_we = 1; pal_sel = 3'(i); pal_color = {6'(63 - i), 6'(i * 8), 6'(i * 3)};
            @(negedge clk); @(negedge clk);
        end
        pal_we = 0;
        // R7: redraw back store while scanning, swap request held for 3 cycles
        for (int x = 0; x < HA; x++) draw(x, 4, 6);
        swap_req = 1; repeat (3) @(negedge clk); swap_req = 0;
        wait_done();
        // R6: request in the cycle before the blank-start edge, with a draw on that edge
        while (!(m_hc == 0 && m_vc == VA)) @(negedge clk);
        swap_req = 1; draw_en = 1; draw_x = 10'd3; draw_y = 10'd1; draw_idx = 3'd2;
        @(negedge clk);
        swap_req = 0; draw_en = 0;
        check(swap_done === 1'b0, "R6 no flip on the request edge", swap_done, 0);
        wait_done();
        // R7: draw on the exact flip edge
        while (!(m_hc == 0 && m_vc == VA)) @(negedge clk);
        // R6 a request already pending gains nothing extra: only one done
        done_seen = 0;
        pulse_swap();
        while (!(m_hc == 0 && m_vc == VA)) @(negedge clk);
        draw_en = 1; draw_x = 10'd7; draw_y = 10'd6; draw_idx = 3'd4; swap_req = 1;
        @(negedge clk);
        draw_en = 0; swap_req = 0;
        repeat (2 * HT * VT) @(negedge clk);
        check(done_seen == 1, "R6 single done for merged requests", 24'(done_seen), 1);
        repeat (HT * VT) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule